// File: doc/BRIEF.md
# External interrupt request controller

This block watches seven external request pins: six maskable pins and one non-maskable pin. Every pin passes through a two-flop synchroniser. Each maskable pin then feeds a detector whose condition can be selected per pin. A detected condition latches a per-pin status flag. Software clears these flags by writing ones to them.

The flags are masked by per-pin enable bits. They are then ranked by programmable 3-bit priority levels. The winning request is presented to the CPU together with its vector number and level. The non-maskable pin has its own selectable edge. It beats every maskable request and is not affected by any enable bit.

Any pending non-maskable flag, or any enabled maskable flag, drives a wake-up output for leaving standby. Configuration and status are reached through a small synchronous register bus:

- Address 0 holds the non-maskable edge select.
- Address 1 holds the detection modes.
- Address 2 holds the enables.
- Address 3 holds the priorities.
- Address 4 holds the status flags.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset there is no request and the wake output is low. Every register reads 0, which means low-level detection, all pins disabled, all levels 0, falling-edge non-maskable sensing and no flags.
- R2: A pin change driven before clock edge k reaches the flags and the request outputs at edge k+2. It is not visible after edge k+1.
- R3: In detection mode 00 (low level), a flag is set on every cycle that the synchronised pin is low. A flag cleared while the pin stays low is therefore set again.
- R4: Mode 01 sets the flag on a falling edge, mode 10 on a rising edge and mode 11 on either edge. Pin n uses bits 2n+1:2n of register 1.
- R5: A pin whose enable bit (bit n of register 2) is 0 still records its flag, but it produces neither a request nor wake-up.
- R6: Among flagged, enabled pins, the highest level wins. The level of pin n is in bits 3n+2:3n of register 3. On equal levels the lower pin index wins. The request carries vector 16+n and the pin's level.
- R7: Writing 1 to bit n of register 4 clears flag n, and writing 1 to bit 6 clears the non-maskable flag. When a new detection occurs in the same cycle as a clear, the flag stays set.
- R8: The non-maskable flag is set on a rising edge when bit 0 of register 0 is 1, and on a falling edge when it is 0. While that flag is set, the request reports vector 7 and level 7, whatever the enables and flags of the maskable pins.
- R9: The wake output is high exactly when the non-maskable flag or at least one enabled maskable flag is set.
- R10: Registers 0 to 3 read back the values written to them, and register 4 reads the non-maskable flag in bit 6 and pin flags in bits 5:0. Read data appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIrq | input | 6 | Maskable request pins, asynchronous |
| pinNmi | input | 1 | Non-maskable request pin, asynchronous |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 18 | Write data |
| busRdData | output | 18 | Read data, registered |
| irqReq | output | 1 | Request to the CPU |
| irqVector | output | 8 | Vector number of the winning request |
| irqLevel | output | 3 | Priority level of the winning request |
| wakeOut | output | 1 | Standby wake-up request |

## Verification
A stale or wrongly set flag shows up at the request and wake outputs in the same cycle as the flag register. A fault in the synchroniser or in edge detection appears two cycles after the pin moves, as a missing or extra request. A wrong ranking shows as a wrong vector or level while two or more flags are pending. Because all of these surface within a cycle or two, a per-cycle comparison of the outputs against an independent model catches them almost at once. Directed reads of the flag register expose faults that a mask hides.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_PINS  = 6;
  localparam int PRIO_W    = 3;
  localparam int MODE_W    = 2;
  localparam int ADDR_W    = 3;
  localparam int VEC_W     = 8;
  localparam int VEC_BASE  = 16;
  localparam int NMI_VEC   = 7;
  localparam int IDX_W     = $clog2(NUM_PINS);
  localparam int BUS_W     = NUM_PINS * PRIO_W;
  localparam int FLAG_W    = NUM_PINS + 1;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PRIO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

  typedef enum logic [MODE_W-1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } detMode_e;

  typedef struct packed {
    logic              wrCfg;
    logic              wrMode;
    logic              wrEnable;
    logic              wrPrio;
    logic [FLAG_W-1:0] clrMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [BUS_W-1:0]           wrData,
  input  logic [NUM_PINS-1:0]        pinIrq,
  input  logic                       pinNmi,
  output logic                       cfgNmiRise,
  output logic [NUM_PINS*MODE_W-1:0] modeReg,
  output logic [NUM_PINS-1:0]        enableReg,
  output logic [BUS_W-1:0]           prioReg,
  output logic [NUM_PINS-1:0]        flags,
  output logic                       nmiFlag
);
  logic [NUM_PINS-1:0] syncA, syncB, syncPrev, det;
  logic nmiA, nmiB, nmiPrev, nmiDet;

  // Two-flop synchronisers plus one history stage; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1; syncB <= '1; syncPrev <= '1;
      nmiA <= 1'b1; nmiB <= 1'b1; nmiPrev <= 1'b1;
    end else begin
      syncA <= pinIrq; syncB <= syncA; syncPrev <= syncB;
      nmiA <= pinNmi; nmiB <= nmiA; nmiPrev <= nmiB;
    end
  end

  // Per-pin condition detection
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      unique case (detMode_e'(modeReg[i*MODE_W +: MODE_W]))
        DET_LOW:  det[i] = ~syncB[i];
        DET_FALL: det[i] = ~syncB[i] & syncPrev[i];
        DET_RISE: det[i] = syncB[i] & ~syncPrev[i];
        DET_BOTH: det[i] = syncB[i] ^ syncPrev[i];
      endcase
    end
  end

  assign nmiDet = cfgNmiRise ? (nmiB & ~nmiPrev) : (~nmiB & nmiPrev);

  // Status flags: detection outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      nmiFlag <= 1'b0;
    end else begin
      flags   <= (flags & ~strobe.clrMask[NUM_PINS-1:0]) | det;
      nmiFlag <= (nmiFlag & ~strobe.clrMask[NUM_PINS]) | nmiDet;
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgNmiRise <= 1'b0;
      modeReg    <= '0;
      enableReg  <= '0;
      prioReg    <= '0;
    end else begin
      if (strobe.wrCfg)    cfgNmiRise <= wrData[0];
      if (strobe.wrMode)   modeReg    <= wrData[NUM_PINS*MODE_W-1:0];
      if (strobe.wrEnable) enableReg  <= wrData[NUM_PINS-1:0];
      if (strobe.wrPrio)   prioReg    <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gFlagChk
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      det[g] |=> flags[g]);
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrMask[g] && !det[g]) |=> !flags[g]);
  end

  // R8
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiDet |=> nmiFlag);
endmodule

// File: rtl/xirq_control.sv
module xirq_control
  import xirq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [FLAG_W-1:0]          wrClrBits,
  input  logic                       cfgNmiRise,
  input  logic [NUM_PINS*MODE_W-1:0] modeReg,
  input  logic [NUM_PINS-1:0]        enableReg,
  input  logic [BUS_W-1:0]           prioReg,
  input  logic [NUM_PINS-1:0]        flags,
  input  logic                       nmiFlag,
  output ctrlStrobe_t                strobe,
  output logic [BUS_W-1:0]           rdData,
  output logic                       irqReq,
  output logic [VEC_W-1:0]           irqVector,
  output logic [PRIO_W-1:0]          irqLevel
);
  logic              found;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestLvl;
  logic [NUM_PINS-1:0] live;

  // Bus decode into strobes
  always_comb begin
    strobe.wrCfg    = wrEn && (addr == ADDR_CFG);
    strobe.wrMode   = wrEn && (addr == ADDR_MODE);
    strobe.wrEnable = wrEn && (addr == ADDR_EN);
    strobe.wrPrio   = wrEn && (addr == ADDR_PRIO);
    strobe.clrMask  = (wrEn && (addr == ADDR_FLAG)) ? wrClrBits : '0;
  end

  // Registered read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      unique case (addr)
        ADDR_CFG:  rdData <= BUS_W'(cfgNmiRise);
        ADDR_MODE: rdData <= BUS_W'(modeReg);
        ADDR_EN:   rdData <= BUS_W'(enableReg);
        ADDR_PRIO: rdData <= prioReg;
        ADDR_FLAG: rdData <= BUS_W'({nmiFlag, flags});
        default:   rdData <= '0;
      endcase
    end
  end

  // Arbitration: ascending scan with strict compare keeps lower index on ties
  assign live = flags & enableReg;
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (live[i] && (!found || prioReg[i*PRIO_W +: PRIO_W] > bestLvl)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestLvl = prioReg[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign irqReq    = nmiFlag | found;
  assign irqVector = nmiFlag ? VEC_W'(NMI_VEC) : VEC_W'(VEC_BASE) + VEC_W'(bestIdx);
  assign irqLevel  = nmiFlag ? '1 : bestLvl;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gArbChk
    // R5
    disabled_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irqReq && irqVector == VEC_W'(VEC_BASE + g)) |-> (enableReg[g] && flags[g]));
    // R6
    level_max_chk: assert property (@(posedge clk) disable iff (!rstN)
      (live[g] && !nmiFlag) |-> (irqLevel >= prioReg[g*PRIO_W +: PRIO_W]));
  end

  // R8
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiFlag |-> (irqReq && irqVector == VEC_W'(NMI_VEC) && irqLevel == '1));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIrq,
  input  logic                pinNmi,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  output logic                irqReq,
  output logic [VEC_W-1:0]    irqVector,
  output logic [PRIO_W-1:0]   irqLevel,
  output logic                wakeOut
);
  ctrlStrobe_t                strobe;
  logic                       cfgNmiRise;
  logic [NUM_PINS*MODE_W-1:0] modeReg;
  logic [NUM_PINS-1:0]        enableReg;
  logic [BUS_W-1:0]           prioReg;
  logic [NUM_PINS-1:0]        flags;
  logic                       nmiFlag;

  xirq_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .pinIrq(pinIrq), .pinNmi(pinNmi), .cfgNmiRise(cfgNmiRise),
    .modeReg(modeReg), .enableReg(enableReg), .prioReg(prioReg),
    .flags(flags), .nmiFlag(nmiFlag)
  );

  xirq_control ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrClrBits(busWrData[FLAG_W-1:0]), .cfgNmiRise(cfgNmiRise),
    .modeReg(modeReg), .enableReg(enableReg), .prioReg(prioReg),
    .flags(flags), .nmiFlag(nmiFlag), .strobe(strobe), .rdData(busRdData),
    .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel)
  );

  assign wakeOut = nmiFlag | (|(flags & enableReg));

  // R9
  wake_on_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wakeOut);
endmodule

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  pinIrq = '1;
  logic        pinNmi = 1'b1;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [17:0] busWrData = '0;
  logic [17:0] busRdData;
  logic        irqReq, wakeOut;
  logic [7:0]  irqVector;
  logic [2:0]  irqLevel;

  int checks = 0, failures = 0;
  bit checkOn = 0;

  always #2 clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pinIrq(pinIrq), .pinNmi(pinNmi),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq),
    .irqVector(irqVector), .irqLevel(irqLevel), .wakeOut(wakeOut)
  );

  // Reference model built from the requirements
  logic [5:0]  s1, s2, s3, mFlag, mEn, det;
  logic        n1, n2, n3, mNmi, mCfg, nd;
  logic [11:0] mMode;
  logic [17:0] mPrio;
  logic [6:0]  clr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 = '1; s2 = '1; s3 = '1; n1 = 1; n2 = 1; n3 = 1;
      mCfg = 0; mMode = '0; mEn = '0; mPrio = '0; mFlag = '0; mNmi = 0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        case (mMode[2*i +: 2])
          2'b00:   det[i] = !s2[i];
          2'b01:   det[i] = !s2[i] && s3[i];
          2'b10:   det[i] = s2[i] && !s3[i];
          default: det[i] = s2[i] != s3[i];
        endcase
      end
      nd  = mCfg ? (n2 && !n3) : (!n2 && n3);
      clr = (busWrEn && busAddr == 3'd4) ? busWrData[6:0] : 7'd0;
      mFlag = (mFlag & ~clr[5:0]) | det;
      mNmi  = (mNmi && !clr[6]) || nd;
      if (busWrEn) begin
        case (busAddr)
          3'd0: mCfg  = busWrData[0];
          3'd1: mMode = busWrData[11:0];
          3'd2: mEn   = busWrData[5:0];
          3'd3: mPrio = busWrData;
          default: ;
        endcase
      end
      s3 = s2; s2 = s1; s1 = pinIrq;
      n3 = n2; n2 = n1; n1 = pinNmi;
    end
  end

  function automatic logic [12:0] expOut();
    logic r; logic [7:0] v; logic [2:0] l; logic w;
    r = 0; v = 8'd16; l = 0;
    w = mNmi || |(mFlag & mEn);
    for (int i = 0; i < 6; i++)
      if (mFlag[i] && mEn[i] && (!r || mPrio[3*i +: 3] > l)) begin
        r = 1; v = 8'(16 + i); l = mPrio[3*i +: 3];
      end
    if (mNmi) begin r = 1; v = 8'd7; l = 3'd7; end
    return {r, v, l, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R6, R9)
  always @(negedge clk) begin
    if (checkOn) begin
      logic [12:0] e;
      e = expOut();
      if (e[12]) check("R6 per-cycle req/vec/lvl/wake", {19'd0, irqReq, irqVector, irqLevel, wakeOut}, {19'd0, e});
      else       check("R9 per-cycle idle req/wake", {30'd0, irqReq, wakeOut}, {30'd0, e[12], e[0]});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [17:0] d);
    @(negedge clk); busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [17:0] exp, input string tag);
    @(negedge clk); busRdEn = 1; busAddr = a;
    @(negedge clk); busRdEn = 0;
    check(tag, 32'(busRdData), 32'(exp));
  endtask

  task automatic expect_out(input logic r, input logic [7:0] v, input logic [2:0] l, input logic w, input string tag);
    if (r) check(tag, {19'd0, irqReq, irqVector, irqLevel, wakeOut}, {19'd0, r, v, l, w});
    else   check(tag, {30'd0, irqReq, wakeOut}, {30'd0, r, w});
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    waitN(3);
    rstN = 1;
    checkOn = 1;
    waitN(1);
    // R1 reset state
    expect_out(0, 0, 0, 0, "R1 reset outputs");
    for (int a = 0; a < 5; a++) rd(3'(a), 18'd0, "R1 reset register");

    // R10 readback
    wr(3'd1, 18'h555); wr(3'd2, 18'h3F); wr(3'd3, 18'h0); wr(3'd0, 18'h0);
    rd(3'd1, 18'h555, "R10 mode readback");
    rd(3'd2, 18'h3F, "R10 enable readback");

    // R2 synchroniser latency
    @(negedge clk); pinIrq[0] = 0;
    @(negedge clk); expect_out(0, 0, 0, 0, "R2 not after edge k");
    @(negedge clk); expect_out(0, 0, 0, 0, "R2 not after edge k+1");
    @(negedge clk); expect_out(1, 8'd16, 3'd0, 1, "R2 visible after edge k+2");

    // R7 write-one clear
    wr(3'd4, 18'h01);
    expect_out(0, 0, 0, 0, "R7 clear removes request");
    rd(3'd4, 18'h0, "R7 flag reads clear");

    // R4 rising and both-edge modes
    wr(3'd1, 18'h556);
    pinIrq[0] = 1; waitN(3);
    expect_out(1, 8'd16, 3'd0, 1, "R4 rising edge");
    wr(3'd4, 18'h01);
    wr(3'd1, 18'h557);
    pinIrq[0] = 0; waitN(3);
    rd(3'd4, 18'h01, "R4 both edges fall");
    wr(3'd4, 18'h01);
    pinIrq[0] = 1; waitN(3);
    rd(3'd4, 18'h01, "R4 both edges rise");
    wr(3'd4, 18'h01);
    rd(3'd4, 18'h00, "R4 falling mode pin1 idle no flag");

    // R3 low level, and R7 clear during detection
    wr(3'd1, 18'h547);
    pinIrq[2] = 0; waitN(3);
    rd(3'd4, 18'h04, "R3 low level sets flag");
    wr(3'd4, 18'h04);
    rd(3'd4, 18'h04, "R3 R7 clear while low keeps flag");
    pinIrq[2] = 1; waitN(3);
    wr(3'd4, 18'h04);
    rd(3'd4, 18'h00, "R3 released pin clears");

    // R6 priority and tie
    wr(3'd3, 18'hA18);
    pinIrq[1] = 0; pinIrq[3] = 0; waitN(3);
    expect_out(1, 8'd19, 3'd5, 1, "R6 higher level wins");
    wr(3'd3, 18'hA28);
    expect_out(1, 8'd17, 3'd5, 1, "R6 tie to lower index");
    // R5 disabled pins
    wr(3'd2, 18'h35);
    expect_out(0, 0, 0, 0, "R5 disabled not forwarded");
    rd(3'd4, 18'h0A, "R5 disabled flags recorded");
    wr(3'd2, 18'h3F); wr(3'd4, 18'h0A);
    pinIrq[1] = 1; pinIrq[3] = 1; waitN(3);

    // R8 non-maskable
    pinIrq[3] = 0; pinNmi = 0; waitN(3);
    expect_out(1, 8'd7, 3'd7, 1, "R8 nmi falling wins");
    wr(3'd2, 18'h0);
    expect_out(1, 8'd7, 3'd7, 1, "R8 nmi ignores enables");
    wr(3'd4, 18'h40);
    expect_out(0, 0, 0, 0, "R9 no wake when only disabled flags");
    wr(3'd2, 18'h3F);
    expect_out(1, 8'd19, 3'd5, 1, "R8 after nmi cleared");
    wr(3'd0, 18'h1);
    pinNmi = 1; waitN(3);
    expect_out(1, 8'd7, 3'd7, 1, "R8 nmi rising");
    wr(3'd4, 18'h48);
    expect_out(0, 0, 0, 0, "R7 clear nmi and pin");
    pinIrq[3] = 1; waitN(3);

    // Random phase, checked every cycle against the model
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      for (int p = 0; p < 6; p++) if ($urandom % 10 == 0) pinIrq[p] = ~pinIrq[p];
      if ($urandom % 40 == 0) pinNmi = ~pinNmi;
      busWrEn = ($urandom % 8 == 0);
      busAddr = 3'($urandom % 5);
      busWrData = 18'($urandom);
    end
    @(negedge clk); busWrEn = 0;
    waitN(4);
    checkOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule